// File: doc/BRIEF.md
# Page Translation Cache with User/System Protection

This block is a small, fully associative cache of page translations that sits in front of a page-table walker. Each slot pairs a 20-bit linear page number with a 20-bit physical frame number and two effective permission bits. A lookup presents a 32-bit linear address, an access direction and the current privilege level. One cycle later the block returns one of three outcomes. On a hit that is permitted, it returns the physical address. On a hit that breaks page protection, it raises a fault with an error code. When no slot matches, it reports a miss.

On a miss the walker later returns a fill. The fill carries the page number, the frame number and the user/system and write bits from both the directory level and the table level. The block merges these into one permission pair and places the entry in a slot. A flush input clears every slot. The surrounding logic pulses it whenever the page-directory base is rewritten.

The protection check has two levels. Privilege levels 0 to 2 are treated as system level, and level 3 as user level. A system page refuses user-level access. A read-only page refuses user-level writes. System-level accesses ignore the read/write bit.

Top module: `pg_xlate_cache`

## Requirements
- R1: After reset every slot is invalid and `rsp_valid_o`, `rsp_ok_o`, `rsp_miss_o` and `rsp_fault_o` are 0, so the first lookup of any page misses.
- R2: A lookup accepted at a clock edge produces exactly one cycle of `rsp_valid_o` after that edge. On a permitted hit, `rsp_ok_o`=1 and `rsp_phys_o` = {stored frame number, linear address bits 11:0}. Without a lookup, `rsp_valid_o` is 0.
- R3: When no valid slot holds the linear page number, the response has `rsp_miss_o`=1, `rsp_ok_o`=0, `rsp_fault_o`=0 and `rsp_phys_o`=0. Exactly one of ok, miss and fault is set in each response.
- R4: A fill accepted at an edge is visible to lookups from the next edge on. A lookup in the same cycle as the fill sees the contents from before the fill.
- R5: The stored user permission is the AND of the directory and table user/system bits. The stored write permission is the AND of the directory and table read/write bits.
- R6: At privilege levels 0, 1 and 2, a hit never faults, whatever the stored permission bits are.
- R7: At privilege level 3, a hit on an entry whose stored user permission is 0 faults for both reads and writes.
- R8: At privilege level 3, a write to an entry whose stored write permission is 0 faults, while a read of it succeeds if user access is allowed.
- R9: A faulting response has `rsp_ok_o`=0 and `rsp_phys_o`=0. Its `rsp_err_o` has bit 0 = 1 (page present), bit 1 = the access was a write, and bit 2 = the access was at user level. On responses without a fault, `rsp_err_o` is 0.
- R10: A fill of a new page goes into the lowest-numbered invalid slot.
- R11: When all slots are valid, a fill of a new page replaces the slot at a round-robin pointer. The pointer is 0 after reset, advances by one per such replacement, wraps after the last slot, and is not changed by a flush.
- R12: A fill whose page number is already held overwrites that slot in place. It neither takes a second slot nor moves the pointer.
- R13: A flush clears every slot from the next edge on. A fill in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate all slots (directory base rewritten) |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Linear address to translate |
| lk_write_i | input | 1 | Lookup is a write access |
| lk_cpl_i | input | 2 | Current privilege level, 3 = user |
| fill_valid_i | input | 1 | Walker result is presented |
| fill_vpn_i | input | 20 | Linear page number of the fill |
| fill_pfn_i | input | 20 | Physical frame number of the fill |
| fill_dir_us_i | input | 1 | Directory-level user/system bit |
| fill_dir_rw_i | input | 1 | Directory-level read/write bit |
| fill_tbl_us_i | input | 1 | Table-level user/system bit |
| fill_tbl_rw_i | input | 1 | Table-level read/write bit |
| rsp_valid_o | output | 1 | Response present |
| rsp_ok_o | output | 1 | Translation succeeded, physical address valid |
| rsp_miss_o | output | 1 | No matching slot |
| rsp_fault_o | output | 1 | Protection fault on a hit |
| rsp_err_o | output | 3 | Fault code: {user, write, present} |
| rsp_phys_o | output | 32 | Physical address |

## Verification
Two pairs of functions can fall in the same cycle. A fill can arrive together with a lookup of the same page, and a flush can arrive together with a fill. The bench drives both pairs on one edge. In the first case the same-cycle lookup must miss and the next lookup must hit. In the second case neither the new page nor an older page may hit afterwards. The permission logic is swept over all sixteen combinations of directory and table bits, times every privilege level and both directions. Eviction order is judged by which pages survive after the slots are filled past capacity and one slot is overwritten in place.

// File: rtl/xc_pkg.sv
package xc_pkg;
  // merged permission held in each slot
  typedef struct packed {
    logic usr_ok;  // user level may reach the page
    logic wr_ok;   // user level may write the page
  } perm_t;

  // privilege level treated as user level
  localparam int unsigned USER_CPL = 3;
endpackage

// File: rtl/xc_tag_array.sv
module xc_tag_array
  import xc_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  input  logic [VPN_W-1:0]   probe_vpn_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [PFN_W-1:0]   wr_pfn_i,
  input  perm_t              wr_perm_i,
  output logic [ENTRIES-1:0] lk_hit_vec_o,
  output logic [ENTRIES-1:0] probe_hit_vec_o,
  output logic [ENTRIES-1:0] valid_vec_o,
  output logic [PFN_W-1:0]   rd_pfn_o,
  output perm_t              rd_perm_o
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];

  // valid bits: flush dominates any write in the same cycle
  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  // payload storage, single write port, no reset
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      vpn_q[wr_idx_i]  <= probe_vpn_i;
      pfn_q[wr_idx_i]  <= wr_pfn_i;
      perm_q[wr_idx_i] <= wr_perm_i;
    end
  end

  // parallel compare for the lookup port and the fill probe
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lk_hit_vec_o[e]    = valid_q[e] && (vpn_q[e] == lk_vpn_i);
    assign probe_hit_vec_o[e] = valid_q[e] && (vpn_q[e] == probe_vpn_i);
  end

  // one-hot read mux built from OR terms
  always_comb begin
    rd_pfn_o  = '0;
    rd_perm_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec_o[i]) begin
        rd_pfn_o  = rd_pfn_o | pfn_q[i];
        rd_perm_o = perm_t'(rd_perm_o | perm_q[i]);
      end
    end
  end

  assign valid_vec_o = valid_q;

  // never two slots for one page (relies on in-place overwrite)
  assert_single_match_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec_o));

  assert_flush_empties_R13: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (valid_q == '0));

endmodule

// File: rtl/xc_victim_sel.sv
module xc_victim_sel #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec_i,
  input  logic [ENTRIES-1:0] probe_hit_vec_i,
  input  logic               fill_go_i,
  output logic [IDX_W-1:0]   wr_idx_o
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] match_idx;
  logic             any_free;
  logic             any_match;
  logic             evict;

  // lowest invalid slot: scan downward so the last assignment wins
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec_i[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (probe_hit_vec_i[i]) match_idx = IDX_W'(i);
    end
  end

  assign any_free  = ~&valid_vec_i;
  assign any_match = |probe_hit_vec_i;
  assign evict     = fill_go_i && !any_match && !any_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (evict) begin
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_comb begin
    if (any_match)     wr_idx_o = match_idx;
    else if (any_free) wr_idx_o = free_idx;
    else               wr_idx_o = ptr_q;
  end

  assert_ptr_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !evict |=> $stable(ptr_q));

  assert_free_slot_target_R10: assert property (@(posedge clk) disable iff (rst)
    (fill_go_i && !any_match && any_free) |-> !valid_vec_i[wr_idx_o]);

endmodule

// File: rtl/xc_perm_check.sv
module xc_perm_check
  import xc_pkg::*;
#(
  parameter int CPL_W = 2
) (
  input  logic [CPL_W-1:0] cpl_i,
  input  logic             write_i,
  input  perm_t            perm_i,
  output logic             fault_o,
  output logic [2:0]       err_o
);

  logic user_lvl;

  assign user_lvl = (cpl_i == CPL_W'(USER_CPL));

  // system level passes everything; user level needs usr_ok, and wr_ok for writes
  assign fault_o = user_lvl && (!perm_i.usr_ok || (write_i && !perm_i.wr_ok));
  assign err_o   = {user_lvl, write_i, 1'b1};

endmodule

// File: rtl/pg_xlate_cache.sv
module pg_xlate_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int CPL_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush_i,
  input  logic                   lk_valid_i,
  input  logic [VPN_W+OFF_W-1:0] lk_addr_i,
  input  logic                   lk_write_i,
  input  logic [CPL_W-1:0]       lk_cpl_i,
  input  logic                   fill_valid_i,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [PFN_W-1:0]       fill_pfn_i,
  input  logic                   fill_dir_us_i,
  input  logic                   fill_dir_rw_i,
  input  logic                   fill_tbl_us_i,
  input  logic                   fill_tbl_rw_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_ok_o,
  output logic                   rsp_miss_o,
  output logic                   rsp_fault_o,
  output logic [2:0]             rsp_err_o,
  output logic [PFN_W+OFF_W-1:0] rsp_phys_o
);

  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PHYS_W = PFN_W + OFF_W;

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] lk_hit_vec;
  logic [ENTRIES-1:0] probe_hit_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [PFN_W-1:0]   rd_pfn;
  perm_t              rd_perm;
  perm_t              fill_perm;
  logic [IDX_W-1:0]   wr_idx;
  logic               fill_go;
  logic               hit_any;
  logic               chk_fault;
  logic [2:0]         chk_err;
  logic               ok_c;
  logic               fault_c;

  assign lk_vpn  = lk_addr_i[OFF_W +: VPN_W];
  assign lk_off  = lk_addr_i[OFF_W-1:0];
  assign fill_go = fill_valid_i && !flush_i;

  // both levels must grant a right for the slot to grant it
  assign fill_perm.usr_ok = fill_dir_us_i & fill_tbl_us_i;
  assign fill_perm.wr_ok  = fill_dir_rw_i & fill_tbl_rw_i;

  xc_tag_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .IDX_W   (IDX_W)
  ) tags_i (
    .clk             (clk),
    .rst             (rst),
    .flush_i         (flush_i),
    .lk_vpn_i        (lk_vpn),
    .probe_vpn_i     (fill_vpn_i),
    .wr_en_i         (fill_go),
    .wr_idx_i        (wr_idx),
    .wr_pfn_i        (fill_pfn_i),
    .wr_perm_i       (fill_perm),
    .lk_hit_vec_o    (lk_hit_vec),
    .probe_hit_vec_o (probe_hit_vec),
    .valid_vec_o     (valid_vec),
    .rd_pfn_o        (rd_pfn),
    .rd_perm_o       (rd_perm)
  );

  xc_victim_sel #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) victim_i (
    .clk             (clk),
    .rst             (rst),
    .valid_vec_i     (valid_vec),
    .probe_hit_vec_i (probe_hit_vec),
    .fill_go_i       (fill_go),
    .wr_idx_o        (wr_idx)
  );

  xc_perm_check #(
    .CPL_W (CPL_W)
  ) perm_i (
    .cpl_i   (lk_cpl_i),
    .write_i (lk_write_i),
    .perm_i  (rd_perm),
    .fault_o (chk_fault),
    .err_o   (chk_err)
  );

  assign hit_any = |lk_hit_vec;
  assign ok_c    = lk_valid_i && hit_any && !chk_fault;
  assign fault_c = lk_valid_i && hit_any && chk_fault;

  // registered response stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_err_o   <= '0;
      rsp_phys_o  <= '0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_ok_o    <= ok_c;
      rsp_miss_o  <= lk_valid_i && !hit_any;
      rsp_fault_o <= fault_c;
      rsp_err_o   <= fault_c ? chk_err : 3'b000;
      rsp_phys_o  <= ok_c ? {rd_pfn, lk_off} : PHYS_W'(0);
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid_i |=> rsp_valid_o);

  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid_i |=> !rsp_valid_o);

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> ($countones({rsp_ok_o, rsp_miss_o, rsp_fault_o}) == 1));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid_o |-> !(rsp_ok_o || rsp_miss_o || rsp_fault_o));

  assert_fault_code_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_fault_o |-> (rsp_err_o[0] && !rsp_ok_o && (rsp_phys_o == '0)));

  assert_system_no_fault_R6: assert property (@(posedge clk) disable iff (rst)
    (lk_valid_i && (lk_cpl_i != CPL_W'(USER_CPL))) |=> !rsp_fault_o);

endmodule

// File: tb/pg_xlate_cache_tb_top.sv
`timescale 1ns/1ps
module pg_xlate_cache_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        flush_i;
  logic        lk_valid_i;
  logic [31:0] lk_addr_i;
  logic        lk_write_i;
  logic [1:0]  lk_cpl_i;
  logic        fill_valid_i;
  logic [19:0] fill_vpn_i;
  logic [19:0] fill_pfn_i;
  logic        fill_dir_us_i, fill_dir_rw_i, fill_tbl_us_i, fill_tbl_rw_i;
  logic        rsp_valid_o, rsp_ok_o, rsp_miss_o, rsp_fault_o;
  logic [2:0]  rsp_err_o;
  logic [31:0] rsp_phys_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  pg_xlate_cache dut_i (
    .clk           (clk),
    .rst           (rst),
    .flush_i       (flush_i),
    .lk_valid_i    (lk_valid_i),
    .lk_addr_i     (lk_addr_i),
    .lk_write_i    (lk_write_i),
    .lk_cpl_i      (lk_cpl_i),
    .fill_valid_i  (fill_valid_i),
    .fill_vpn_i    (fill_vpn_i),
    .fill_pfn_i    (fill_pfn_i),
    .fill_dir_us_i (fill_dir_us_i),
    .fill_dir_rw_i (fill_dir_rw_i),
    .fill_tbl_us_i (fill_tbl_us_i),
    .fill_tbl_rw_i (fill_tbl_rw_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_ok_o      (rsp_ok_o),
    .rsp_miss_o    (rsp_miss_o),
    .rsp_fault_o   (rsp_fault_o),
    .rsp_err_o     (rsp_err_o),
    .rsp_phys_o    (rsp_phys_o)
  );

  function automatic logic [19:0] frame_of(input logic [19:0] vpn);
    return vpn ^ 20'h5A5A5;
  endfunction

  task automatic idle_inputs();
    flush_i = 0; lk_valid_i = 0; lk_addr_i = '0; lk_write_i = 0; lk_cpl_i = '0;
    fill_valid_i = 0; fill_vpn_i = '0; fill_pfn_i = '0;
    fill_dir_us_i = 0; fill_dir_rw_i = 0; fill_tbl_us_i = 0; fill_tbl_rw_i = 0;
  endtask

  // one clock with any mix of lookup, fill and flush; outputs sampled after it
  task automatic step(input logic lv, input logic [31:0] addr, input logic wr,
                      input logic [1:0] cpl, input logic fv, input logic [19:0] vpn,
                      input logic [19:0] pfn, input logic [3:0] pb, input logic fl);
    @(negedge clk);
    lk_valid_i = lv; lk_addr_i = addr; lk_write_i = wr; lk_cpl_i = cpl;
    fill_valid_i = fv; fill_vpn_i = vpn; fill_pfn_i = pfn;
    {fill_dir_us_i, fill_dir_rw_i, fill_tbl_us_i, fill_tbl_rw_i} = pb;
    flush_i = fl;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [3:0] pb);
    step(0, '0, 0, 0, 1, vpn, pfn, pb, 0);
  endtask

  task automatic look(input logic [31:0] addr, input logic wr, input logic [1:0] cpl);
    step(1, addr, wr, cpl, 0, '0, '0, '0, 0);
  endtask

  task automatic expect_rsp(input string req, input logic e_ok, input logic e_miss,
                            input logic e_flt, input logic [2:0] e_err, input logic [31:0] e_phys);
    total++;
    if (rsp_valid_o !== 1'b1 || rsp_ok_o !== e_ok || rsp_miss_o !== e_miss ||
        rsp_fault_o !== e_flt || rsp_err_o !== e_err || rsp_phys_o !== e_phys) begin
      bad++;
      $display("FAIL %s: got v=%0b ok=%0b miss=%0b flt=%0b err=%0h phys=%h exp v=1 ok=%0b miss=%0b flt=%0b err=%0h phys=%h",
               req, rsp_valid_o, rsp_ok_o, rsp_miss_o, rsp_fault_o, rsp_err_o, rsp_phys_o,
               e_ok, e_miss, e_flt, e_err, e_phys);
    end
  endtask

  task automatic expect_hit(input string req, input logic [19:0] vpn, input logic [19:0] pfn,
                            input logic [11:0] off);
    look({vpn, off}, 0, 2'd0);
    expect_rsp(req, 1, 0, 0, 3'b000, {pfn, off});
  endtask

  task automatic expect_miss(input string req, input logic [19:0] vpn);
    look({vpn, 12'h321}, 0, 2'd0);
    expect_rsp(req, 0, 1, 0, 3'b000, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got no end, expected end of run");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: idle outputs after reset
    total++;
    if (rsp_valid_o !== 0 || rsp_ok_o !== 0 || rsp_miss_o !== 0 || rsp_fault_o !== 0) begin
      bad++;
      $display("FAIL R1: got v=%0b ok=%0b miss=%0b flt=%0b expected all 0",
               rsp_valid_o, rsp_ok_o, rsp_miss_o, rsp_fault_o);
    end
    expect_miss("R1", 20'h00100);
    expect_miss("R3", 20'hFFFFF);

    // R4: fill and lookup of the same page in one cycle
    step(1, {20'h000AB, 12'h010}, 0, 2'd0, 1, 20'h000AB, frame_of(20'h000AB), 4'hF, 0);
    expect_rsp("R4", 0, 1, 0, 3'b000, 32'h0);
    expect_hit("R4", 20'h000AB, frame_of(20'h000AB), 12'hABC);
    // R2: no response after a cycle without a lookup
    @(negedge clk);
    total++;
    if (rsp_valid_o !== 0) begin
      bad++;
      $display("FAIL R2: got rsp_valid=%0b expected 0", rsp_valid_o);
    end

    // permission sweep: all directory/table bit mixes, levels, directions
    for (int p = 0; p < 16; p++) fill(20'h00100 + 20'(p), frame_of(20'h00100 + 20'(p)), 4'(p));
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 4; c++) begin
        for (int w = 0; w < 2; w++) begin
          logic [19:0] vpn;
          logic [11:0] off;
          logic us, rw, usr, flt;
          string req;
          vpn = 20'h00100 + 20'(p);
          off = 12'(p * 37 + c * 5 + w);
          us  = p[3] & p[1];   // R5 directory AND table
          rw  = p[2] & p[0];
          usr = (c == 3);
          flt = usr && (!us || (w == 1 && !rw));
          if (!usr)                req = "R6";
          else if (!us)            req = "R7";
          else if (w == 1 && !rw)  req = "R8";
          else                     req = "R5";
          look({vpn, off}, 1'(w), 2'(c));
          if (flt) expect_rsp({req, "/R9"}, 0, 0, 1, {usr, 1'(w), 1'b1}, 32'h0);
          else     expect_rsp({req, "/R2"}, 1, 0, 0, 3'b000, {frame_of(vpn), off});
        end
      end
    end

    // R13: flush empties the cache
    step(0, '0, 0, 0, 0, '0, '0, '0, 1);
    expect_miss("R13", 20'h00100);
    expect_miss("R13", 20'h000AB);

    // R10: fill every slot in order; first-filled page must go to slot 0
    for (int k = 0; k < 32; k++) fill(20'h00200 + 20'(k), frame_of(20'h00200 + 20'(k)), 4'hF);
    for (int k = 0; k < 32; k++)
      expect_hit("R10", 20'h00200 + 20'(k), frame_of(20'h00200 + 20'(k)), 12'(k));

    // R11: full cache, pointer 0 then 1 (flush left it at 0)
    fill(20'h00220, frame_of(20'h00220), 4'hF);
    fill(20'h00221, frame_of(20'h00221), 4'hF);
    expect_miss("R11", 20'h00200);
    expect_miss("R11", 20'h00201);
    expect_hit("R11", 20'h00202, frame_of(20'h00202), 12'h002);
    expect_hit("R11", 20'h00220, frame_of(20'h00220), 12'h020);
    expect_hit("R11", 20'h00221, frame_of(20'h00221), 12'h021);

    // R12: overwrite in place, pointer stays at 2
    fill(20'h00202, 20'hC0DE2, 4'hF);
    expect_hit("R12", 20'h00202, 20'hC0DE2, 12'h777);
    fill(20'h00222, frame_of(20'h00222), 4'hF);
    expect_miss("R12", 20'h00202);
    expect_hit("R12", 20'h00203, frame_of(20'h00203), 12'h003);

    // R13: flush and fill in the same cycle, fill discarded
    step(0, '0, 0, 0, 1, 20'h00333, frame_of(20'h00333), 4'hF, 1);
    expect_miss("R13", 20'h00333);
    expect_miss("R13", 20'h00203);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule